// File: doc/BRIEF.md
# Dual-Mode SPI Clock Divider

This block derives the serial clock of an SPI master from its module clock. Two divide laws are available and a single mode bit picks between them. The linear law divides by twice the linear field plus two, giving any even ratio from 2 to 512. The power-of-two law divides by two raised to the exponent field. An exponent of zero bypasses the divider and forwards the module clock itself. The serial clock idles low. Alongside it the block emits one-cycle strobes that mark the first module-clock cycle of each high half and of each low half, so that a shift engine can launch and capture data without sampling the serial clock.

A new mode or field value is taken up only when the serial clock falls, which is where one period ends and the next begins. A period that is already running is never cut short. While enable is low the divider is parked: the serial clock sits at 0 and the half-period counter is held at zero.

A combinational rate planner is included. It takes a requested divide ratio and returns a mode and the field values. The linear law is preferred. The power-of-two law is used only when the linear field cannot hold the value needed. The result is always rounded towards the slower clock.

Top module: `spiclk_divider`

## Requirements
- R1: With mode_i = 0 (linear) and lin_div_i = n, the serial clock is high for n+1 module-clock cycles and low for n+1 cycles, which gives a period of 2·(n+1). This holds for every n from 0 to 255.
- R2: With mode_i = 1 (power of two) and exp_div_i = n, where 1 ≤ n ≤ 15, the serial clock is high for 2^(n-1) cycles and low for 2^(n-1) cycles, which gives a period of 2^n.
- R3: With mode_i = 1 and exp_div_i = 0, sck_o follows clk_i while enabled, and rise_stb_o and fall_stb_o are both 1 in every cycle. When the block leaves this mode it restarts with a full low half.
- R4: The field that the current mode does not use has no effect on the serial clock.
- R5: One cycle after en_i is sampled low, sck_o, rise_stb_o and fall_stb_o are all 0. The configuration seen while disabled applies to the first period. After en_i is sampled high, sck_o first rises on the H-th rising edge of clk_i, where H is the half-period length.
- R6: In the divided modes, rise_stb_o is 1 for exactly the first module-clock cycle in which sck_o is high, and fall_stb_o is 1 for exactly the first cycle in which it is low. The two strobes are never 1 together. The first low half after enable, or after leaving bypass, has no fall strobe.
- R7: A change of mode_i, lin_div_i or exp_div_i takes effect only at the next falling edge of sck_o. The half period in progress keeps its old length, and every low half has the same length as the high half that follows it.
- R8: The planner treats a requested ratio R of 0 as 1. If R ≤ 512 it returns plan_mode_o = 0 and plan_lin_o = ceil(R/2) − 1, with plan_exp_o = 0.
- R9: If R > 512 the planner returns plan_mode_o = 1, plan_lin_o = 0, and the smallest plan_exp_o with 2^plan_exp_o ≥ R. The planned period is never below R.
- R10: While rst_ni is low, sck_o, rise_stb_o and fall_stb_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable |
| mode_i | input | 1 | Divide law: 0 linear, 1 power of two |
| lin_div_i | input | LIN_W (8) | Linear field n, period 2·(n+1) |
| exp_div_i | input | EXP_W (4) | Exponent field n, period 2^n |
| req_ratio_i | input | RATIO_W (15) | Planner input: requested module-clock/serial-clock ratio |
| sck_o | output | 1 | Serial clock, idle low |
| rise_stb_o | output | 1 | First cycle of each high half |
| fall_stb_o | output | 1 | First cycle of each low half |
| plan_mode_o | output | 1 | Planner: chosen divide law |
| plan_lin_o | output | LIN_W (8) | Planner: linear field value |
| plan_exp_o | output | EXP_W (4) | Planner: exponent field value |

## Verification
The following are checked by assertions in every cycle:
- outputs go idle after enable drops;
- each strobe is one cycle wide and matches the level of the serial clock;
- each low half equals the high half after it, even across configuration changes;
- the planner keeps the period at or above the request, and picks the linear law whenever it can.

Some behaviour can only be shown by the bench's scenarios. These are the absolute periods, checked against both formulas for every field value; the module clock passing through in bypass; the exact latency from enable to the first rising edge; and the unused field being ignored.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

   typedef enum logic {
      DIV_LINEAR = 1'b0,
      DIV_POW2   = 1'b1
   } div_mode_e;

   // Width of the half-period-minus-one count for the given field widths.
   function automatic int spiclk_half_w(input int lin_w, input int exp_w);
      int pow_w;
      pow_w = (1 << exp_w) - 2;
      if (pow_w < 1) pow_w = 1;
      return (lin_w > pow_w) ? lin_w : pow_w;
   endfunction

endpackage

// File: rtl/spiclk_half_calc.sv
module spiclk_half_calc #(
   parameter int LIN_W  = 8,
   parameter int EXP_W  = 4,
   parameter int HALF_W = 14
) (
   input  logic              pow2_i,
   input  logic [LIN_W-1:0]  lin_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic              bypass_o,
   output logic [HALF_W-1:0] hm1_o
);

   logic [EXP_W-1:0] exp_m1;

   always_comb begin
      exp_m1 = exp_i - EXP_W'(1);
      if (pow2_i) begin
         bypass_o = (exp_i == '0);
         // half period 2^(n-1); the top case wraps to all ones, which is exact
         hm1_o    = (HALF_W'(1) << exp_m1) - HALF_W'(1);
      end else begin
         bypass_o = 1'b0;
         hm1_o    = HALF_W'(lin_i);
      end
   end

endmodule

// File: rtl/spiclk_edge_gen.sv
module spiclk_edge_gen #(
   parameter int HALF_W = 14
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              nxt_bypass_i,
   input  logic [HALF_W-1:0] nxt_hm1_i,
   output logic              sck_o,
   output logic              rise_stb_o,
   output logic              fall_stb_o
);

   logic              run_q;
   logic              byp_q;
   logic              sck_q;
   logic              rise_q;
   logic              fall_q;
   logic [HALF_W-1:0] hm1_q;
   logic [HALF_W-1:0] cnt_q;
   logic              at_limit;

   assign at_limit = (cnt_q == hm1_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         byp_q  <= 1'b0;
         sck_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         hm1_q  <= '0;
         cnt_q  <= '0;
      end else if (!en_i) begin
         // parked: the configuration keeps loading so the first period uses it
         run_q  <= 1'b0;
         sck_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         cnt_q  <= '0;
         byp_q  <= nxt_bypass_i;
         hm1_q  <= nxt_hm1_i;
      end else begin
         run_q <= 1'b1;
         if (byp_q) begin
            // every module-clock cycle is a period boundary in bypass
            byp_q  <= nxt_bypass_i;
            hm1_q  <= nxt_hm1_i;
            cnt_q  <= '0;
            sck_q  <= 1'b0;
            rise_q <= nxt_bypass_i;
            fall_q <= nxt_bypass_i;
         end else if (at_limit) begin
            cnt_q  <= '0;
            sck_q  <= ~sck_q;
            rise_q <= ~sck_q;
            fall_q <= sck_q;
            if (sck_q) begin
               // falling edge closes the period: take up the new settings
               byp_q <= nxt_bypass_i;
               hm1_q <= nxt_hm1_i;
               if (nxt_bypass_i) begin
                  rise_q <= 1'b1;
                  fall_q <= 1'b1;
               end
            end
         end else begin
            cnt_q  <= cnt_q + HALF_W'(1);
            rise_q <= 1'b0;
            fall_q <= 1'b0;
         end
      end
   end

   assign sck_o      = run_q & (byp_q ? clk_i : sck_q);
   assign rise_stb_o = rise_q;
   assign fall_stb_o = fall_q;

endmodule

// File: rtl/spiclk_rate_planner.sv
module spiclk_rate_planner
   import spiclk_pkg::*;
#(
   parameter int LIN_W   = 8,
   parameter int EXP_W   = 4,
   parameter int RATIO_W = 15
) (
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               mode_o,
   output logic [LIN_W-1:0]   lin_o,
   output logic [EXP_W-1:0]   exp_o
);

   localparam logic [31:0] LIN_MAX = 32'((1 << LIN_W) - 1);
   localparam int          EXP_MAX = (1 << EXP_W) - 1;

   logic [31:0] ratio_eff;
   logic [31:0] lin_need;
   div_mode_e   mode_sel;

   always_comb begin
      ratio_eff = (ratio_i == '0) ? 32'd1 : 32'(ratio_i);
      // ceil(R/2) - 1 rounds the frequency down
      lin_need  = ((ratio_eff + 32'd1) >> 1) - 32'd1;
      if (lin_need <= LIN_MAX) begin
         mode_sel = DIV_LINEAR;
         lin_o    = LIN_W'(lin_need);
         exp_o    = '0;
      end else begin
         mode_sel = DIV_POW2;
         lin_o    = '0;
         exp_o    = EXP_W'(EXP_MAX);
         for (int i = EXP_MAX; i >= 0; i--) begin
            if ((32'd1 << i) >= ratio_eff) exp_o = EXP_W'(i);
         end
      end
      mode_o = mode_sel;
   end

endmodule

// File: rtl/spiclk_divider.sv
module spiclk_divider
   import spiclk_pkg::*;
#(
   parameter int LIN_W      = 8,
   parameter int EXP_W      = 4,
   parameter int RATIO_W    = 15,
   parameter bit PLANNER_EN = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               mode_i,
   input  logic [LIN_W-1:0]   lin_div_i,
   input  logic [EXP_W-1:0]   exp_div_i,
   input  logic [RATIO_W-1:0] req_ratio_i,
   output logic               sck_o,
   output logic               rise_stb_o,
   output logic               fall_stb_o,
   output logic               plan_mode_o,
   output logic [LIN_W-1:0]   plan_lin_o,
   output logic [EXP_W-1:0]   plan_exp_o
);

   localparam int HALF_W = spiclk_half_w(LIN_W, EXP_W);

   if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin
      $error("spiclk_divider: LIN_W must be within 1..16");
   end
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("spiclk_divider: EXP_W must be within 1..5");
   end
   if (RATIO_W < 2 || RATIO_W > 30 || RATIO_W > (1 << EXP_W) - 1) begin : g_bad_ratio
      $error("spiclk_divider: RATIO_W must be 2..30 and reachable by the exponent field");
   end

   div_mode_e         mode_sel;
   logic              nxt_bypass;
   logic [HALF_W-1:0] nxt_hm1;

   assign mode_sel = div_mode_e'(mode_i);

   spiclk_half_calc #(
      .LIN_W (LIN_W),
      .EXP_W (EXP_W),
      .HALF_W(HALF_W)
   ) u_half (
      .pow2_i  (mode_sel == DIV_POW2),
      .lin_i   (lin_div_i),
      .exp_i   (exp_div_i),
      .bypass_o(nxt_bypass),
      .hm1_o   (nxt_hm1)
   );

   spiclk_edge_gen #(
      .HALF_W(HALF_W)
   ) u_edge (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_i),
      .nxt_bypass_i(nxt_bypass),
      .nxt_hm1_i   (nxt_hm1),
      .sck_o       (sck_o),
      .rise_stb_o  (rise_stb_o),
      .fall_stb_o  (fall_stb_o)
   );

   if (PLANNER_EN) begin : g_planner
      spiclk_rate_planner #(
         .LIN_W  (LIN_W),
         .EXP_W  (EXP_W),
         .RATIO_W(RATIO_W)
      ) u_plan (
         .ratio_i(req_ratio_i),
         .mode_o (plan_mode_o),
         .lin_o  (plan_lin_o),
         .exp_o  (plan_exp_o)
      );
   end else begin : g_no_planner
      assign plan_mode_o = 1'b0;
      assign plan_lin_o  = '0;
      assign plan_exp_o  = '0;
   end

endmodule

// File: rtl/spiclk_divider_chk.sv
module spiclk_divider_chk #(
   parameter int LIN_W      = 8,
   parameter int EXP_W      = 4,
   parameter int RATIO_W    = 15,
   parameter bit PLANNER_EN = 1'b1,
   parameter int HALF_W     = 14
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               en_i,
   input logic [RATIO_W-1:0] req_ratio_i,
   input logic               sck_o,
   input logic               rise_stb_o,
   input logic               fall_stb_o,
   input logic               plan_mode_o,
   input logic [LIN_W-1:0]   plan_lin_o,
   input logic [EXP_W-1:0]   plan_exp_o
);

   logic rise_only;
   logic fall_only;
   assign rise_only = rise_stb_o & ~fall_stb_o;
   assign fall_only = fall_stb_o & ~rise_stb_o;

   // R5: disabled one cycle -> everything idle
   a_r5_idle_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!sck_o && !rise_stb_o && !fall_stb_o));

   // R6: strobes match the clock level and last a single cycle
   a_r6_rise_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_only |-> sck_o);
   a_r6_fall_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_only |-> !sck_o);
   a_r6_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_only |=> !rise_stb_o);
   a_r6_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_only |=> !fall_stb_o);

   // R7: each low half equals the following high half
   logic [HALF_W+1:0] run_cnt_q;
   logic [HALF_W+1:0] low_len_q;
   logic              seen_fall_q;
   logic              have_low_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_cnt_q   <= '0;
         low_len_q   <= '0;
         seen_fall_q <= 1'b0;
         have_low_q  <= 1'b0;
      end else if (!en_i || (rise_stb_o && fall_stb_o)) begin
         run_cnt_q   <= '0;
         seen_fall_q <= 1'b0;
         have_low_q  <= 1'b0;
      end else if (fall_only) begin
         run_cnt_q   <= (HALF_W+2)'(1);
         seen_fall_q <= 1'b1;
      end else if (rise_only) begin
         low_len_q   <= run_cnt_q;
         have_low_q  <= seen_fall_q;
         run_cnt_q   <= (HALF_W+2)'(1);
      end else begin
         run_cnt_q   <= run_cnt_q + (HALF_W+2)'(1);
      end
   end

   a_r7_even_halves: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fall_only && have_low_q) |-> (run_cnt_q == low_len_q));

   if (PLANNER_EN) begin : g_plan_chk
      logic [31:0] ratio_eff;
      logic [31:0] plan_period;
      assign ratio_eff   = (req_ratio_i == '0) ? 32'd1 : 32'(req_ratio_i);
      assign plan_period = plan_mode_o ? (32'd1 << plan_exp_o)
                                       : (32'd2 * (32'(plan_lin_o) + 32'd1));

      // R9: never faster than requested
      a_r9_not_faster: assert property (@(posedge clk_i) disable iff (!rst_ni)
         plan_period >= ratio_eff);
      // R8: linear law whenever the field can hold it
      a_r8_prefer_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ratio_eff <= 32'(2 << LIN_W)) |-> !plan_mode_o);
      // R8: linear choice is the closest one not faster than requested
      a_r8_linear_tight: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !plan_mode_o |-> (plan_lin_o == '0 || 32'd2 * 32'(plan_lin_o) < ratio_eff));
   end

endmodule

bind spiclk_divider spiclk_divider_chk #(
   .LIN_W     (LIN_W),
   .EXP_W     (EXP_W),
   .RATIO_W   (RATIO_W),
   .PLANNER_EN(PLANNER_EN),
   .HALF_W    (HALF_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .en_i       (en_i),
   .req_ratio_i(req_ratio_i),
   .sck_o      (sck_o),
   .rise_stb_o (rise_stb_o),
   .fall_stb_o (fall_stb_o),
   .plan_mode_o(plan_mode_o),
   .plan_lin_o (plan_lin_o),
   .plan_exp_o (plan_exp_o)
);

// File: tb/spiclk_divider_bench.sv
`timescale 1ns/1ps
module spiclk_divider_bench;

   localparam int LIN_W   = 8;
   localparam int EXP_W   = 4;
   localparam int RATIO_W = 15;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               en;
   logic               mode;
   logic [LIN_W-1:0]   lin;
   logic [EXP_W-1:0]   expf;
   logic [RATIO_W-1:0] req;
   logic               sck;
   logic               rise;
   logic               fall;
   logic               p_mode;
   logic [LIN_W-1:0]   p_lin;
   logic [EXP_W-1:0]   p_exp;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   spiclk_divider #(
      .LIN_W(LIN_W), .EXP_W(EXP_W), .RATIO_W(RATIO_W), .PLANNER_EN(1'b1)
   ) u_spiclk_divider (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
      .lin_div_i(lin), .exp_div_i(expf), .req_ratio_i(req),
      .sck_o(sck), .rise_stb_o(rise), .fall_stb_o(fall),
      .plan_mode_o(p_mode), .plan_lin_o(p_lin), .plan_exp_o(p_exp)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp_v);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp_v);
      end
   endtask

   task automatic scramble(input bit scr_lin, input bit scr_exp);
      if (scr_lin) lin  = lin + LIN_W'(37);
      if (scr_exp) expf = expf + EXP_W'(5);
   endtask

   task automatic wait_fall(input bit scr_lin, input bit scr_exp);
      int guard = 0;
      do begin
         @(negedge clk);
         scramble(scr_lin, scr_exp);
         guard++;
      end while (!(fall && !rise) && guard < 70000);
   endtask

   task automatic count_to(input bit want_rise, input bit scr_lin, input bit scr_exp,
                           output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (!(want_rise ? (rise && !fall) : (fall && !rise))) scramble(scr_lin, scr_exp);
      end while (!(want_rise ? (rise && !fall) : (fall && !rise)) && n < 70000);
   endtask

   task automatic t_reset();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(!sck && !rise && !fall, "R10", "outputs during reset",
               {sck, rise, fall}, 0);
      end
      rst_n = 1'b1;
   endtask

   task automatic t_enable();
      int first = 0;
      @(negedge clk);
      en = 1'b0;
      mode = 1'b0;
      lin = LIN_W'(4);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(!sck && !rise && !fall, "R5", "idle while disabled", {sck, rise, fall}, 0);
      end
      en = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         if (first == 0 && rise) first = k;
         if (first == 0) check(!sck, "R5", "low before first rise", sck, 0);
      end
      check(first == 5, "R5", "edge index of first rise", first, 5);
   endtask

   task automatic t_lin_sweep();
      int lo, hi;
      mode = 1'b0;
      lin  = '0;
      wait_fall(1'b0, 1'b0);
      for (int n = 0; n <= 255; n++) begin
         count_to(1'b1, 1'b0, 1'b0, lo);
         check(sck == 1'b1, "R6", "level at rise strobe", sck, 1);
         lin = (n < 255) ? LIN_W'(n + 1) : '0;   // change mid-period (R7)
         count_to(1'b0, 1'b0, 1'b0, hi);
         check(sck == 1'b0, "R6", "level at fall strobe", sck, 0);
         check(lo == n + 1, "R1", "linear low half", lo, n + 1);
         check(hi == n + 1, "R7", "linear high half kept old length", hi, n + 1);
      end
   endtask

   task automatic t_pow2_sweep();
      int lo, hi;
      mode = 1'b1;
      expf = EXP_W'(1);
      wait_fall(1'b0, 1'b0);
      for (int n = 1; n <= 15; n++) begin
         count_to(1'b1, 1'b0, 1'b0, lo);
         expf = (n < 15) ? EXP_W'(n + 1) : EXP_W'(1);
         count_to(1'b0, 1'b0, 1'b0, hi);
         check(lo == (1 << (n - 1)), "R2", "pow2 low half", lo, 1 << (n - 1));
         check(hi == (1 << (n - 1)), "R2", "pow2 high half", hi, 1 << (n - 1));
      end
   endtask

   task automatic t_ignore();
      int lo, hi;
      mode = 1'b0;
      lin  = LIN_W'(3);
      wait_fall(1'b0, 1'b1);
      count_to(1'b1, 1'b0, 1'b1, lo);
      count_to(1'b0, 1'b0, 1'b1, hi);
      check(lo == 4 && hi == 4, "R4", "linear ignores exponent", lo * 100 + hi, 404);
      mode = 1'b1;
      expf = EXP_W'(3);
      wait_fall(1'b1, 1'b0);
      count_to(1'b1, 1'b1, 1'b0, lo);
      count_to(1'b0, 1'b1, 1'b0, hi);
      check(lo == 4 && hi == 4, "R4", "pow2 ignores linear field", lo * 100 + hi, 404);
   endtask

   task automatic t_bypass();
      int guard = 0;
      int lo, hi;
      mode = 1'b1;
      expf = '0;
      do begin
         @(negedge clk);
         guard++;
      end while (!(rise && fall) && guard < 100);
      check(rise && fall, "R3", "bypass reached", {rise, fall}, 3);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk);
         #2;
         check(sck == 1'b1, "R3", "follows clock high", sck, 1);
         @(negedge clk);
         #2;
         check(sck == 1'b0 && rise && fall, "R3", "follows clock low, strobes set",
               {sck, rise, fall}, 3);
      end
      mode = 1'b0;
      lin  = LIN_W'(1);
      wait_fall(1'b0, 1'b0);
      count_to(1'b1, 1'b0, 1'b0, lo);
      count_to(1'b0, 1'b0, 1'b0, hi);
      check(lo == 2 && hi == 2, "R3", "clean exit from bypass", lo * 100 + hi, 202);
   endtask

   task automatic t_planner();
      int ratios [12] = '{0, 1, 2, 3, 4, 5, 511, 512, 513, 1024, 1025, 32767};
      foreach (ratios[i]) begin
         int r, em, el, ee, per;
         r = (ratios[i] == 0) ? 1 : ratios[i];
         if (r <= 512) begin
            em = 0; el = (r + 1) / 2 - 1; ee = 0;
         end else begin
            em = 1; el = 0; ee = 0;
            while ((1 << ee) < r) ee++;
         end
         @(negedge clk);
         req = RATIO_W'(ratios[i]);
         #1;
         if (em == 0) begin
            check(p_mode == 1'b0 && int'(p_lin) == el, "R8", "linear plan",
                  int'(p_mode) * 1000 + int'(p_lin), el);
         end else begin
            check(p_mode == 1'b1 && int'(p_exp) == ee && p_lin == '0, "R9", "pow2 plan",
                  int'(p_mode) * 1000 + int'(p_exp), 1000 + ee);
         end
         per = p_mode ? (1 << p_exp) : 2 * (int'(p_lin) + 1);
         check(per >= r, "R9", "planned period not below request", per, r);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      en    = 1'b1;
      mode  = 1'b0;
      lin   = LIN_W'(3);
      expf  = '0;
      req   = '0;
      t_reset();
      t_enable();
      t_lin_sweep();
      t_pow2_sweep();
      t_ignore();
      t_bypass();
      t_planner();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule